// File: doc/BRIEF.md
# Fixed-point load address and result formatter

This unit runs one 64-bit fixed-point load from start to finish. A decoded load enters on a valid/ready handshake. It carries the access size, a signed flag, a byte-reverse flag, an update flag and an addressing form. It also carries the two source register numbers and their values, the raw 16-bit immediate and the destination register number. In the same cycle the unit forms the effective address and, if the operation is legal, issues a read of 1, 2, 4 or 8 bytes to memory. The memory answers one cycle later. The unit then formats the returned bytes and writes them to the destination register. For update forms it writes the effective address back to the base register in the same cycle as the destination write.

Back-pressure: `ld_ready` is high only while the unit is idle. An operation is taken on a cycle where both `ld_valid` and `ld_ready` are high. From the cycle after acceptance until the response arrives, `ld_ready` is low and any `ld_valid` is ignored. The memory side has no back-pressure: a request is taken in the cycle it is shown. An illegal update form is rejected at once. No request is sent, and the only result is a one-cycle `bad_form` pulse.

Top module: `lfu_load_unit`

## Requirements
- R1: For a load without update, an `ra_sel` of 0 makes the base zero whatever `ra_value` holds. Any other `ra_sel` makes the base `ra_value`.
- R2: `ld_form` = 0 selects the displacement form: the address is the base plus the sign-extended 16-bit `imm_field`.
- R3: `ld_form` = 1 selects the scaled displacement form. Bits 1:0 of `imm_field` are ignored and replaced by zeros before sign extension, so the offset is a multiple of 4.
- R4: `ld_form` = 2 or 3 selects the indexed form: the address is the base plus `rb_value`.
- R5: For a legal operation, `mem_req_valid` is high in the acceptance cycle. `mem_req_addr` carries the address and `mem_req_bytes` equals 2 to the power of `ld_size` (size 0..3 means 1, 2, 4, 8 bytes).
- R6: The fetched data sits right-aligned on `mem_rsp_data`, with the lowest-addressed byte most significant. With `ld_signed` = 0 and `ld_brev` = 0, the result is that value and all higher bits are zero.
- R7: With `ld_signed` = 1 and `ld_brev` = 0, the fetched value is sign-extended to 64 bits from its top bit.
- R8: With `ld_brev` = 1, the byte order of the fetched value is reversed and bits above it are cleared. `ld_signed` has no effect in this case.
- R9: For an update form, the base is always `ra_value`, even when `ra_sel` is 0. The effective address is written to register `ra_sel` in the same cycle as the destination write.
- R10: An update form with `ra_sel` = 0 or `ra_sel` = `rt_sel` is illegal. `bad_form` pulses one cycle after acceptance, no memory request is made, and neither register is written.
- R11: `rt_we` rises the cycle after `mem_rsp_valid`. `ld_ready` is low while a response is awaited, and operations shown then cause no request and no write.
- R12: After reset, `ld_ready` is high and `mem_req_valid`, `rt_we`, `ra_we` and `bad_form` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load operation offered |
| ld_ready | output | 1 | Unit idle and able to take an operation |
| ld_size | input | 2 | Access size, log2 of the byte count |
| ld_signed | input | 1 | Sign-extend the fetched value |
| ld_brev | input | 1 | Byte-reverse the fetched value |
| ld_update | input | 1 | Write the address back to the base register |
| ld_form | input | 2 | 0 displacement, 1 scaled displacement, 2/3 indexed |
| ra_sel | input | 5 | Base register number |
| ra_value | input | 64 | Base register contents |
| rb_value | input | 64 | Index register contents |
| imm_field | input | 16 | Raw immediate field |
| rt_sel | input | 5 | Destination register number |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 64 | Read address |
| mem_req_bytes | output | 4 | Bytes requested (1, 2, 4 or 8) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-aligned |
| rt_we | output | 1 | Destination register write |
| rt_wr_idx | output | 5 | Destination register number |
| rt_wr_data | output | 64 | Formatted load result |
| ra_we | output | 1 | Base register write (update forms) |
| ra_wr_idx | output | 5 | Base register number for the write |
| ra_wr_data | output | 64 | Effective address written back |
| bad_form | output | 1 | Illegal update form rejected |

## Verification
The memory request and its address are combinational from the accepted operation, so they are due in the acceptance cycle. The bench checks them a little after it drives the operation, before the clock edge. `bad_form` is due one cycle after acceptance. The two register writes are due one cycle after the response strobe, and the bench checks each at the falling edge that follows the edge where it is registered. A per-clock monitor holds every write strobe, the reject pulse and the request strobe low in every cycle where no result is due. A stray or late strobe therefore fails in the cycle it appears.

// File: rtl/lfu_pkg.sv
package lfu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE   = 2'd0,
    SZ_HALF   = 2'd1,
    SZ_WORD   = 2'd2,
    SZ_DOUBLE = 2'd3
  } lfu_size_e;

  typedef enum logic [1:0] {
    FORM_DISP   = 2'd0,
    FORM_SCALED = 2'd1,
    FORM_INDEX  = 2'd2,
    FORM_INDEX2 = 2'd3
  } lfu_form_e;

  localparam int unsigned LFU_SIZES = 4;
endpackage

// File: rtl/lfu_agen.sv
module lfu_agen
  import lfu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter int RW   = 5
) (
  input  logic [1:0]      form,
  input  logic            update,
  input  logic [RW-1:0]   ra_sel,
  input  logic [XLEN-1:0] ra_value,
  input  logic [XLEN-1:0] rb_value,
  input  logic [IMMW-1:0] imm_field,
  output logic [XLEN-1:0] ea
);
  localparam int EXTW = XLEN - IMMW;

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offset;
  logic [IMMW-1:0] imm_scaled;

  // update forms always take the register; otherwise register 0 reads as zero
  assign base       = (update || (ra_sel != '0)) ? ra_value : '0;
  assign imm_scaled = {imm_field[IMMW-1:2], 2'b00};

  always_comb begin
    unique case (lfu_form_e'(form))
      FORM_DISP:   offset = {{EXTW{imm_field[IMMW-1]}}, imm_field};
      FORM_SCALED: offset = {{EXTW{imm_scaled[IMMW-1]}}, imm_scaled};
      default:     offset = rb_value;
    endcase
  end

  assign ea = base + offset;
endmodule

// File: rtl/lfu_fmt.sv
module lfu_fmt
  import lfu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      size,
  input  logic            sgn,
  input  logic            brev,
  input  logic [XLEN-1:0] raw,
  output logic [XLEN-1:0] result
);
  localparam int NSZ = LFU_SIZES;

  logic [XLEN-1:0] cand [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int W  = 8 << s;
    localparam int NB = W / 8;
    logic [W-1:0] slice;
    logic [W-1:0] rev;

    assign slice = raw[W-1:0];

    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign rev[8*b +: 8] = slice[W-8-8*b +: 8];
    end

    always_comb begin
      cand[s] = '0;
      if (brev) begin
        cand[s][W-1:0] = rev;
      end else begin
        cand[s][W-1:0] = slice;
        if (sgn) begin
          for (int k = W; k < XLEN; k++) cand[s][k] = slice[W-1];
        end
      end
    end
  end

  assign result = cand[size];
endmodule

// File: rtl/lfu_ctrl.sv
module lfu_ctrl #(
  parameter int XLEN = 64,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            accept,
  input  logic            invalid,
  input  logic [1:0]      size,
  input  logic            sgn,
  input  logic            brev,
  input  logic            update,
  input  logic [RW-1:0]   ra_sel,
  input  logic [RW-1:0]   rt_sel,
  input  logic [XLEN-1:0] ea,
  input  logic            rsp_valid,
  input  logic [XLEN-1:0] fmt_result,
  output logic            waiting,
  output logic [1:0]      size_q,
  output logic            sgn_q,
  output logic            brev_q,
  output logic            rt_we,
  output logic [RW-1:0]   rt_wr_idx,
  output logic [XLEN-1:0] rt_wr_data,
  output logic            ra_we,
  output logic [RW-1:0]   ra_wr_idx,
  output logic [XLEN-1:0] ra_wr_data,
  output logic            bad_form
);
  logic            upd_q;
  logic [RW-1:0]   ra_q;
  logic [RW-1:0]   rt_q;
  logic [XLEN-1:0] ea_q;
  logic            take;
  logic            finish;

  assign take   = accept && !invalid;
  assign finish = waiting && rsp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting <= 1'b0;
      bad_form <= 1'b0;
      rt_we <= 1'b0;
      ra_we <= 1'b0;
    end else begin
      bad_form <= accept && invalid;
      rt_we    <= finish;
      ra_we    <= finish && upd_q;
      if (take) waiting <= 1'b1;
      else if (finish) waiting <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      sgn_q <= 1'b0;
      brev_q <= 1'b0;
      upd_q <= 1'b0;
      ra_q <= '0;
      rt_q <= '0;
      ea_q <= '0;
      rt_wr_idx <= '0;
      rt_wr_data <= '0;
      ra_wr_idx <= '0;
      ra_wr_data <= '0;
    end else begin
      if (take) begin
        size_q <= size;
        sgn_q  <= sgn;
        brev_q <= brev;
        upd_q  <= update;
        ra_q   <= ra_sel;
        rt_q   <= rt_sel;
        ea_q   <= ea;
      end
      if (finish) begin
        rt_wr_idx  <= rt_q;
        rt_wr_data <= fmt_result;
        ra_wr_idx  <= ra_q;
        ra_wr_data <= ea_q;
      end
    end
  end
endmodule

// File: rtl/lfu_load_unit.sv
module lfu_load_unit
  import lfu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter int RW   = 5,
  parameter int BW   = LFU_SIZES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_valid,
  output logic            ld_ready,
  input  logic [1:0]      ld_size,
  input  logic            ld_signed,
  input  logic            ld_brev,
  input  logic            ld_update,
  input  logic [1:0]      ld_form,
  input  logic [RW-1:0]   ra_sel,
  input  logic [XLEN-1:0] ra_value,
  input  logic [XLEN-1:0] rb_value,
  input  logic [IMMW-1:0] imm_field,
  input  logic [RW-1:0]   rt_sel,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [BW-1:0]   mem_req_bytes,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            rt_we,
  output logic [RW-1:0]   rt_wr_idx,
  output logic [XLEN-1:0] rt_wr_data,
  output logic            ra_we,
  output logic [RW-1:0]   ra_wr_idx,
  output logic [XLEN-1:0] ra_wr_data,
  output logic            bad_form
);
  logic            waiting;
  logic            accept;
  logic            invalid;
  logic [XLEN-1:0] ea;
  logic [1:0]      size_q;
  logic            sgn_q;
  logic            brev_q;
  logic [XLEN-1:0] fmt_result;

  assign ld_ready = !waiting;
  assign accept   = ld_valid && ld_ready;
  assign invalid  = ld_update && ((ra_sel == '0) || (ra_sel == rt_sel));

  assign mem_req_valid = accept && !invalid;
  assign mem_req_addr  = ea;
  assign mem_req_bytes = BW'(1) << ld_size;

  lfu_agen #(.XLEN(XLEN), .IMMW(IMMW), .RW(RW)) agen_i (
    .form(ld_form), .update(ld_update), .ra_sel(ra_sel),
    .ra_value(ra_value), .rb_value(rb_value), .imm_field(imm_field), .ea(ea)
  );

  lfu_fmt #(.XLEN(XLEN)) fmt_i (
    .size(size_q), .sgn(sgn_q), .brev(brev_q), .raw(mem_rsp_data), .result(fmt_result)
  );

  lfu_ctrl #(.XLEN(XLEN), .RW(RW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .invalid(invalid),
    .size(ld_size), .sgn(ld_signed), .brev(ld_brev), .update(ld_update),
    .ra_sel(ra_sel), .rt_sel(rt_sel), .ea(ea),
    .rsp_valid(mem_rsp_valid), .fmt_result(fmt_result),
    .waiting(waiting), .size_q(size_q), .sgn_q(sgn_q), .brev_q(brev_q),
    .rt_we(rt_we), .rt_wr_idx(rt_wr_idx), .rt_wr_data(rt_wr_data),
    .ra_we(ra_we), .ra_wr_idx(ra_wr_idx), .ra_wr_data(ra_wr_data),
    .bad_form(bad_form)
  );
endmodule

// File: rtl/lfu_load_unit_chk.sv
module lfu_load_unit_chk #(
  parameter int XLEN = 64,
  parameter int IMMW = 16,
  parameter int RW   = 5,
  parameter int BW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_valid,
  input logic            ld_ready,
  input logic            ld_update,
  input logic [RW-1:0]   ra_sel,
  input logic [RW-1:0]   rt_sel,
  input logic            mem_req_valid,
  input logic [BW-1:0]   mem_req_bytes,
  input logic            mem_rsp_valid,
  input logic            rt_we,
  input logic            ra_we,
  input logic [RW-1:0]   ra_wr_idx,
  input logic [RW-1:0]   rt_wr_idx,
  input logic            bad_form
);
  assert_req_needs_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (ld_ready && ld_valid));

  assert_write_follows_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rt_we |-> $past(mem_rsp_valid));

  assert_one_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_req_bytes) == 1));

  assert_ra_pairs_rt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we |-> (rt_we && ra_wr_idx != '0 && ra_wr_idx != rt_wr_idx));

  assert_reject_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && ld_update && (ra_sel == '0 || ra_sel == rt_sel)) |=> bad_form);

  assert_reject_no_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_update && (ra_sel == '0 || ra_sel == rt_sel)) |-> !mem_req_valid);

  assert_reject_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_form |-> (!rt_we && !ra_we));
endmodule

bind lfu_load_unit lfu_load_unit_chk #(.XLEN(XLEN), .IMMW(IMMW), .RW(RW), .BW(BW)) chk_i (.*);

// File: tb/lfu_load_unit_tb_top.sv
module lfu_load_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [1:0]  ld_size = '0;
  logic        ld_signed = 1'b0;
  logic        ld_brev = 1'b0;
  logic        ld_update = 1'b0;
  logic [1:0]  ld_form = '0;
  logic [4:0]  ra_sel = '0;
  logic [63:0] ra_value = '0;
  logic [63:0] rb_value = '0;
  logic [15:0] imm_field = '0;
  logic [4:0]  rt_sel = '0;
  logic        mem_req_valid;
  logic [63:0] mem_req_addr;
  logic [3:0]  mem_req_bytes;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rt_we;
  logic [4:0]  rt_wr_idx;
  logic [63:0] rt_wr_data;
  logic        ra_we;
  logic [4:0]  ra_wr_idx;
  logic [63:0] ra_wr_data;
  logic        bad_form;

  int errors = 0;
  int checks = 0;
  bit busy = 1'b1;
  bit done = 1'b0;
  int cyc = 0;

  always #4 clk = ~clk;

  lfu_load_unit dut_i (.*);

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(logic [63:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'hA5;
  endfunction

  // idle monitor: outside an operation nothing may strobe
  always @(negedge clk) begin
    #2;
    if (!busy && rst_n) begin
      check("R11", "idle strobes", {60'd0, rt_we, ra_we, bad_form, mem_req_valid}, 64'd0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic run_op(string req, int size, bit sgn, bit brev, bit upd, int form,
                        int ra, logic [63:0] rav, logic [63:0] rbv, logic [15:0] imm,
                        int rt, bit poke_busy);
    logic [63:0] base, off, ea, raw, exp;
    logic [15:0] simm;
    int n;
    bit bad;
    n = 1 << size;
    bad = upd && (ra == 0 || ra == rt);
    base = (upd || ra != 0) ? rav : 64'd0;
    if (form == 0) off = {{48{imm[15]}}, imm};
    else if (form == 1) begin
      simm = {imm[15:2], 2'b00};
      off = {{48{simm[15]}}, simm};
    end else off = rbv;
    ea = base + off;
    raw = '0;
    for (int i = 0; i < n; i++) raw = (raw << 8) | {56'd0, mbyte(ea + 64'(i))};
    exp = '0;
    if (brev) begin
      for (int i = 0; i < n; i++) exp[8*i +: 8] = raw[8*(n-1-i) +: 8];
    end else begin
      exp = raw;
      if (sgn && raw[8*n-1]) for (int k = 8*n; k < 64; k++) exp[k] = 1'b1;
    end

    @(negedge clk);
    busy = 1'b1;
    ld_valid = 1'b1; ld_size = 2'(size); ld_signed = sgn; ld_brev = brev;
    ld_update = upd; ld_form = 2'(form); ra_sel = 5'(ra); ra_value = rav;
    rb_value = rbv; imm_field = imm; rt_sel = 5'(rt);
    #1;
    check(req, "ready", {63'd0, ld_ready}, 64'd1);
    check(bad ? "R10" : "R5", "req valid", {63'd0, mem_req_valid}, {63'd0, !bad});
    if (!bad) begin
      check(req, "req addr", mem_req_addr, ea);
      check("R5", "req bytes", {60'd0, mem_req_bytes}, 64'(n));
    end
    @(negedge clk);
    ld_valid = 1'b0;
    if (bad) begin
      #1;
      check("R10", "bad_form", {63'd0, bad_form}, 64'd1);
      check("R10", "writes", {62'd0, rt_we, ra_we}, 64'd0);
      @(negedge clk);
      busy = 1'b0;
      return;
    end
    mem_rsp_valid = 1'b1;
    mem_rsp_data = raw;
    if (poke_busy) begin
      ld_valid = 1'b1; ld_update = 1'b0; ld_form = 2'd2; rb_value = 64'h1000;
    end
    #1;
    check("R11", "ready low while waiting", {63'd0, ld_ready}, 64'd0);
    check("R11", "no req while waiting", {63'd0, mem_req_valid}, 64'd0);
    check("R11", "no early write", {62'd0, rt_we, ra_we}, 64'd0);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    ld_valid = 1'b0;
    #1;
    check("R11", "rt_we", {63'd0, rt_we}, 64'd1);
    check(req, "rt data", rt_wr_data, exp);
    check(req, "rt idx", {59'd0, rt_wr_idx}, 64'(rt));
    check("R9", "ra_we", {63'd0, ra_we}, {63'd0, upd});
    if (upd) begin
      check("R9", "ra data", ra_wr_data, ea);
      check("R9", "ra idx", {59'd0, ra_wr_idx}, 64'(ra));
    end
    check("R11", "ready again", {63'd0, ld_ready}, 64'd1);
    @(negedge clk);
    busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R12", "reset ready", {63'd0, ld_ready}, 64'd1);
    check("R12", "reset strobes", {60'd0, rt_we, ra_we, bad_form, mem_req_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    busy = 1'b0;
    @(negedge clk);
    // R1 base zero, R2 negative displacement, R6 byte zero-extend
    run_op("R1", 0, 0, 0, 0, 0, 0, 64'hDEAD_0000_0000_0000, 64'd0, 16'h0140, 3, 0);
    run_op("R2", 0, 0, 0, 0, 0, 4, 64'h0000_0000_0001_2000, 64'd0, 16'hFFF3, 5, 0);
    run_op("R6", 1, 0, 0, 0, 0, 7, 64'h0000_0000_0000_3000, 64'd0, 16'h0022, 8, 0);
    run_op("R6", 2, 0, 0, 0, 2, 7, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_0035, 16'h0, 9, 0);
    // R7 sign extension across several addresses
    for (int i = 0; i < 6; i++)
      run_op("R7", 1 + (i % 2), 1, 0, 0, 2, 6, 64'h0000_0000_0000_5000, 64'(i * 7), 16'h0, 10, 0);
    // R3 scaled displacement ignores low bits
    run_op("R3", 2, 1, 0, 0, 1, 2, 64'h0000_0000_0000_6000, 64'd0, 16'h0107, 11, 0);
    run_op("R3", 3, 0, 0, 0, 1, 2, 64'h0000_0000_0000_6000, 64'd0, 16'hFFFB, 12, 0);
    // R4 indexed doubleword
    run_op("R4", 3, 0, 0, 0, 3, 9, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0123, 16'hFFFF, 13, 0);
    // R8 byte reverse, sign flag ignored
    run_op("R8", 1, 1, 1, 0, 2, 4, 64'h0000_0000_0000_7001, 64'd4, 16'h0, 14, 0);
    run_op("R8", 2, 1, 1, 0, 2, 4, 64'h0000_0000_0000_7003, 64'd9, 16'h0, 15, 0);
    run_op("R8", 3, 0, 1, 0, 2, 0, 64'd0, 64'h0000_0000_0000_7777, 16'h0, 16, 0);
    // R9 update forms
    run_op("R9", 2, 0, 0, 1, 0, 3, 64'h0000_0000_0000_8000, 64'd0, 16'hFFF0, 17, 0);
    run_op("R9", 3, 0, 0, 1, 2, 21, 64'h0000_0000_0000_8100, 64'h48, 16'h0, 18, 0);
    // R10 illegal update forms
    run_op("R10", 0, 0, 0, 1, 0, 0, 64'h0000_0000_0000_9000, 64'd0, 16'h4, 19, 0);
    run_op("R10", 1, 0, 0, 1, 2, 12, 64'h0000_0000_0000_9000, 64'd8, 16'h0, 12, 0);
    // R11 operation offered while waiting is ignored
    run_op("R11", 0, 0, 0, 0, 2, 5, 64'h0000_0000_0000_A000, 64'd3, 16'h0, 20, 1);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule